// File: doc/BRIEF.md
# Pipelined Pre-Adder Multiply-Accumulate Slice

This block is one arithmetic slice for filter and multiply-accumulate datapaths. Each cycle it takes a multiplicand A, a second operand B, a pre-adder operand D, an addend C and a carry-in. An 18-bit pre-adder can form D+B or D-B in place of B, so that one multiply serves two symmetric taps of a FIR filter. The value that results is multiplied by A in an 18 x 18 signed multiplier. A 48-bit post-adder then adds the sign-extended product to a second operand. That operand comes from a 4-bit mode word that may change on any cycle, and is one of: zero, C, the slice's own result (accumulation) or a cascade input from a neighbouring slice.

The slice has three register stages: input, multiplier and output. Each stage has its own clock enable and its own synchronous active-low clear, and a global synchronous active-low reset clears all three. With every stage registered, a result appears three clock edges after its operands. The output register drives both the result and a cascade output, so slices can be chained into longer filters. Arithmetic wraps modulo 2^48, and a carry-out reports the carry from the top bit of the post-adder.

Top module: `mac_slice`

## Requirements
- R1: With mode[3:2]=00 the result is the 36-bit signed product of A and the multiplier operand, sign-extended to 48 bits. When mode[1]=0 the multiplier operand is B, and mode[0] then has no effect.
- R2: With mode[1]=1 and mode[0]=0 the multiplier operand is D+B, wrapped to 18 signed bits.
- R3: With mode[1]=1 and mode[0]=1 the multiplier operand is D-B, wrapped to 18 signed bits.
- R4: With mode[3:2]=01 the result is the product plus the 48-bit C operand that entered with the same operands.
- R5: With mode[3:2]=10 the result is the product plus the previous result (accumulation).
- R6: With mode[3:2]=11 the result is the product plus the value on the cascade input in the cycle the output register loads.
- R7: The carry-in travels with its operands and is added at bit 0. The carry-out is bit 48 of the unsigned sum of the 48-bit sign-extended product, the second operand and the carry-in.
- R8: The result wraps modulo 2^48, and the pre-adder wraps modulo 2^18.
- R9: A stage whose clock enable is low keeps its contents. A stalled output stage holds result and carry-out unchanged.
- R10: rst_n low clears all three stages on the next edge. A low per-stage clear zeroes only its own stage. Result and carry-out read zero after either.
- R11: With all enables high, operands and mode sampled at edge n produce the result visible after edge n+2. The mode may differ on every cycle, and each mode follows its own operands through the pipeline.
- R12: The cascade output always equals the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of all stages |
| ce_in | input | 1 | Input stage clock enable |
| ce_mul | input | 1 | Multiplier stage clock enable |
| ce_out | input | 1 | Output stage clock enable |
| srst_in_n | input | 1 | Input stage synchronous clear, active low |
| srst_mul_n | input | 1 | Multiplier stage synchronous clear, active low |
| srst_out_n | input | 1 | Output stage synchronous clear, active low |
| mode | input | 4 | [0] subtract, [1] pre-adder on, [3:2] second operand select |
| a | input | 18 | Signed multiplicand |
| b | input | 18 | Signed operand, pre-adder second input |
| d | input | 18 | Signed pre-adder first input |
| c | input | 48 | Post-adder addend |
| carry_in | input | 1 | Post-adder carry-in |
| cascade_in | input | 48 | Result of the neighbouring slice |
| result | output | 48 | Registered post-adder result |
| cascade_out | output | 48 | Copy of result for the next slice |
| carry_out | output | 1 | Registered carry from bit 47 |

## Verification
A corrupted multiplier-stage register shows at the result port on the next output load, which is two edges after the bad operands enter. A mode bit latched into the wrong stage shows as the wrong addend or the wrong pre-adder sign on that one result. In accumulate mode any error in the output register persists, because it is fed back into every later sum, so one bad cycle is still visible on every clock that follows. The behavioural reference tracks all three stages, including enables and clears, and compares result, carry-out and cascade output on every cycle, so a fault is reported in the cycle it first reaches the ports.

// File: rtl/mac_slice_pkg.sv
// Package: shared types and helpers for the multiply-accumulate slice.
// Assumes two's-complement operands throughout.
package mac_slice_pkg;

    // Second post-adder operand selection, mode[3:2]
    typedef enum logic [1:0] {
        ZSEL_ZERO = 2'd0,
        ZSEL_C    = 2'd1,
        ZSEL_ACC  = 2'd2,
        ZSEL_CASC = 2'd3
    } zsel_e;

    localparam int MODE_W = 4;

    // Bit positions inside the mode word
    localparam int MODE_SUB_BIT = 0;
    localparam int MODE_PRE_BIT = 1;
    localparam int MODE_SEL_LO  = 2;

endpackage

// File: rtl/mac_in_stage.sv
// Module: input register stage of the slice.
// Captures operands, mode and carry-in. Reset and clear take priority
// over the clock enable. With USE_REG=0 the stage is a plain wire.
module mac_in_stage
    import mac_slice_pkg::*;
#(
    parameter int A_W     = 18,
    parameter int B_W     = 18,
    parameter int ACC_W   = 48,
    parameter bit USE_REG = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     srst_n,
    input  logic                     ce,
    input  logic signed [A_W-1:0]    a_i,
    input  logic signed [B_W-1:0]    b_i,
    input  logic signed [B_W-1:0]    d_i,
    input  logic [ACC_W-1:0]         c_i,
    input  logic [MODE_W-1:0]        mode_i,
    input  logic                     cin_i,
    output logic signed [A_W-1:0]    a_o,
    output logic signed [B_W-1:0]    b_o,
    output logic signed [B_W-1:0]    d_o,
    output logic [ACC_W-1:0]         c_o,
    output logic [MODE_W-1:0]        mode_o,
    output logic                     cin_o
);

    generate
        if (USE_REG) begin : g_reg
            // Register operands when enabled, clear on either reset
            always_ff @(posedge clk) begin
                if (!rst_n || !srst_n) begin
                    a_o    <= '0;
                    b_o    <= '0;
                    d_o    <= '0;
                    c_o    <= '0;
                    mode_o <= '0;
                    cin_o  <= 1'b0;
                end else if (ce) begin
                    a_o    <= a_i;
                    b_o    <= b_i;
                    d_o    <= d_i;
                    c_o    <= c_i;
                    mode_o <= mode_i;
                    cin_o  <= cin_i;
                end
            end
        end else begin : g_wire
            // Pass operands straight through
            always_comb begin
                a_o    = a_i;
                b_o    = b_i;
                d_o    = d_i;
                c_o    = c_i;
                mode_o = mode_i;
                cin_o  = cin_i;
            end
        end
    endgenerate

endmodule

// File: rtl/mac_mul_stage.sv
// Module: pre-adder, signed multiplier and multiplier register.
// Pre-adder result wraps to B_W bits. The addend, operand select and
// carry-in are delayed alongside the product so that they stay aligned.
module mac_mul_stage
    import mac_slice_pkg::*;
#(
    parameter int A_W     = 18,
    parameter int B_W     = 18,
    parameter int ACC_W   = 48,
    parameter bit USE_REG = 1'b1,
    localparam int PROD_W = A_W + B_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      srst_n,
    input  logic                      ce,
    input  logic signed [A_W-1:0]     a_i,
    input  logic signed [B_W-1:0]     b_i,
    input  logic signed [B_W-1:0]     d_i,
    input  logic [ACC_W-1:0]          c_i,
    input  logic [MODE_W-1:0]         mode_i,
    input  logic                      cin_i,
    output logic signed [PROD_W-1:0]  prod_o,
    output logic [ACC_W-1:0]          c_o,
    output zsel_e                     zsel_o,
    output logic                      cin_o
);

    logic signed [B_W-1:0]    pre_c;
    logic signed [PROD_W-1:0] prod_c;
    zsel_e                    zsel_c;

    // Pre-adder: D+B or D-B when enabled, otherwise B alone
    always_comb begin
        if (mode_i[MODE_PRE_BIT]) begin
            if (mode_i[MODE_SUB_BIT]) pre_c = d_i - b_i;
            else                      pre_c = d_i + b_i;
        end else begin
            pre_c = b_i;
        end
    end

    // Signed multiply and operand-select decode
    always_comb begin
        prod_c = a_i * pre_c;
        zsel_c = zsel_e'(mode_i[MODE_SEL_LO +: 2]);
    end

    generate
        if (USE_REG) begin : g_reg
            // Multiplier pipeline register with enable and clear
            always_ff @(posedge clk) begin
                if (!rst_n || !srst_n) begin
                    prod_o <= '0;
                    c_o    <= '0;
                    zsel_o <= ZSEL_ZERO;
                    cin_o  <= 1'b0;
                end else if (ce) begin
                    prod_o <= prod_c;
                    c_o    <= c_i;
                    zsel_o <= zsel_c;
                    cin_o  <= cin_i;
                end
            end
        end else begin : g_wire
            // Combinational multiplier path
            always_comb begin
                prod_o = prod_c;
                c_o    = c_i;
                zsel_o = zsel_c;
                cin_o  = cin_i;
            end
        end
    endgenerate

endmodule

// File: rtl/mac_post_stage.sv
// Module: 48-bit post-adder and output register.
// The product is sign-extended to ACC_W bits and the sum wraps modulo
// 2^ACC_W. The carry-out is the carry from the top bit of that sum.
// The output register is always present because accumulation reads it.
module mac_post_stage
    import mac_slice_pkg::*;
#(
    parameter int PROD_W = 36,
    parameter int ACC_W  = 48,
    localparam int EXT_W = ACC_W - PROD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      srst_n,
    input  logic                      ce,
    input  logic signed [PROD_W-1:0]  prod_i,
    input  logic [ACC_W-1:0]          c_i,
    input  zsel_e                     zsel_i,
    input  logic                      cin_i,
    input  logic [ACC_W-1:0]          casc_i,
    output logic [ACC_W-1:0]          p_o,
    output logic                      cout_o
);

    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] opnd;
    logic [ACC_W:0]   sum;

    // Choose the second adder operand
    always_comb begin
        unique case (zsel_i)
            ZSEL_ZERO: opnd = '0;
            ZSEL_C:    opnd = c_i;
            ZSEL_ACC:  opnd = p_o;
            ZSEL_CASC: opnd = casc_i;
            default:   opnd = '0;
        endcase
    end

    // Sign-extend product and form the wide sum with carry
    always_comb begin
        prod_ext = {{EXT_W{prod_i[PROD_W-1]}}, prod_i};
        sum      = {1'b0, prod_ext} + {1'b0, opnd} + {{ACC_W{1'b0}}, cin_i};
    end

    // Output register with enable and clear
    always_ff @(posedge clk) begin
        if (!rst_n || !srst_n) begin
            p_o    <= '0;
            cout_o <= 1'b0;
        end else if (ce) begin
            p_o    <= sum[ACC_W-1:0];
            cout_o <= sum[ACC_W];
        end
    end

endmodule

// File: rtl/mac_slice.sv
// Module: top of the multiply-accumulate slice.
// Chains the input stage, the pre-adder/multiplier stage and the
// post-adder stage. Per-stage enables and clears are independent.
// With both optional stages registered, latency is three edges.
module mac_slice
    import mac_slice_pkg::*;
#(
    parameter int A_W         = 18,
    parameter int B_W         = 18,
    parameter int ACC_W       = 48,
    parameter bit USE_IN_REG  = 1'b1,
    parameter bit USE_MUL_REG = 1'b1,
    localparam int PROD_W     = A_W + B_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_in,
    input  logic                    ce_mul,
    input  logic                    ce_out,
    input  logic                    srst_in_n,
    input  logic                    srst_mul_n,
    input  logic                    srst_out_n,
    input  logic [3:0]              mode,
    input  logic signed [A_W-1:0]   a,
    input  logic signed [B_W-1:0]   b,
    input  logic signed [B_W-1:0]   d,
    input  logic [ACC_W-1:0]        c,
    input  logic                    carry_in,
    input  logic [ACC_W-1:0]        cascade_in,
    output logic [ACC_W-1:0]        result,
    output logic [ACC_W-1:0]        cascade_out,
    output logic                    carry_out
);

    logic signed [A_W-1:0]    in_a;
    logic signed [B_W-1:0]    in_b;
    logic signed [B_W-1:0]    in_d;
    logic [ACC_W-1:0]         in_c;
    logic [MODE_W-1:0]        in_mode;
    logic                     in_cin;

    logic signed [PROD_W-1:0] mul_prod;
    logic [ACC_W-1:0]         mul_c;
    zsel_e                    mul_zsel;
    logic                     mul_cin;

    logic [ACC_W-1:0]         p_q;

    mac_in_stage #(
        .A_W(A_W), .B_W(B_W), .ACC_W(ACC_W), .USE_REG(USE_IN_REG)
    ) u_in (
        .clk(clk), .rst_n(rst_n), .srst_n(srst_in_n), .ce(ce_in),
        .a_i(a), .b_i(b), .d_i(d), .c_i(c), .mode_i(mode), .cin_i(carry_in),
        .a_o(in_a), .b_o(in_b), .d_o(in_d), .c_o(in_c),
        .mode_o(in_mode), .cin_o(in_cin)
    );

    mac_mul_stage #(
        .A_W(A_W), .B_W(B_W), .ACC_W(ACC_W), .USE_REG(USE_MUL_REG)
    ) u_mul (
        .clk(clk), .rst_n(rst_n), .srst_n(srst_mul_n), .ce(ce_mul),
        .a_i(in_a), .b_i(in_b), .d_i(in_d), .c_i(in_c),
        .mode_i(in_mode), .cin_i(in_cin),
        .prod_o(mul_prod), .c_o(mul_c), .zsel_o(mul_zsel), .cin_o(mul_cin)
    );

    mac_post_stage #(
        .PROD_W(PROD_W), .ACC_W(ACC_W)
    ) u_post (
        .clk(clk), .rst_n(rst_n), .srst_n(srst_out_n), .ce(ce_out),
        .prod_i(mul_prod), .c_i(mul_c), .zsel_i(mul_zsel), .cin_i(mul_cin),
        .casc_i(cascade_in), .p_o(p_q), .cout_o(carry_out)
    );

    // Drive the result and the chain output from the output register
    always_comb begin
        result      = p_q;
        cascade_out = p_q;
    end

endmodule

// File: rtl/mac_slice_chk.sv
// Checker: temporal properties of the slice, bound to every mac_slice.
// Assumes the output register is always present.
module mac_slice_chk
    import mac_slice_pkg::*;
#(
    parameter int A_W        = 18,
    parameter int B_W        = 18,
    parameter int ACC_W      = 48,
    parameter bit USE_IN_REG = 1'b1,
    localparam int PROD_W    = A_W + B_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ce_in,
    input logic                     ce_out,
    input logic                     srst_in_n,
    input logic                     srst_out_n,
    input logic [3:0]               mode,
    input logic [ACC_W-1:0]         result,
    input logic                     carry_out,
    input logic [MODE_W-1:0]        in_mode,
    input logic signed [PROD_W-1:0] mul_prod,
    input zsel_e                    mul_zsel,
    input logic                     mul_cin
);

    logic [ACC_W-1:0] prod_ext;
    always_comb prod_ext = {{(ACC_W-PROD_W){mul_prod[PROD_W-1]}}, mul_prod};

    // R10: an output clear leaves result and carry at zero
    a_r10_out_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_out_n |=> (result == '0 && !carry_out));

    // R9: a stalled output stage holds its value
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_out_n && !ce_out) |=> ($stable(result) && $stable(carry_out)));

    // R5: accumulation adds the product to the previous result
    a_r5_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_out_n && ce_out && mul_zsel == ZSEL_ACC && !mul_cin)
        |=> (result == $past(result) + $past(prod_ext)));

    // R1: with a zero operand the result is the extended product, no carry
    a_r1_product_only: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_out_n && ce_out && mul_zsel == ZSEL_ZERO && !mul_cin)
        |=> (result == $past(prod_ext) && !carry_out));

    generate
        if (USE_IN_REG) begin : g_in
            // R11: the mode word is captured with its operands
            a_r11_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
                (srst_in_n && ce_in) |=> (in_mode == $past(mode)));
        end
    endgenerate

endmodule

bind mac_slice mac_slice_chk #(
    .A_W(A_W), .B_W(B_W), .ACC_W(ACC_W), .USE_IN_REG(USE_IN_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .ce_out(ce_out),
    .srst_in_n(srst_in_n), .srst_out_n(srst_out_n), .mode(mode),
    .result(result), .carry_out(carry_out), .in_mode(in_mode),
    .mul_prod(mul_prod), .mul_zsel(mul_zsel), .mul_cin(mul_cin)
);

// File: tb/tb_mac_slice.sv
// Bench: drives random and boundary operands, keeps a behavioural
// three-stage reference in integers and compares every clock.
module tb_mac_slice;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               ce_in, ce_mul, ce_out;
    logic               srst_in_n, srst_mul_n, srst_out_n;
    logic [3:0]         mode;
    logic signed [17:0] a, b, d;
    logic [47:0]        c;
    logic               carry_in;
    logic [47:0]        cascade_in;
    logic [47:0]        result, cascade_out;
    logic               carry_out;

    int total = 0;
    int bad   = 0;
    string tag = "R10";

    // Reference state
    longint      r1_a, r1_b, r1_d;
    logic [47:0] r1_c;
    logic [3:0]  r1_mode;
    logic        r1_cin;
    longint      r2_prod;
    logic [47:0] r2_c;
    logic [1:0]  r2_sel;
    logic        r2_cin;
    logic [47:0] r_p;
    logic        r_co;

    always #4 clk = ~clk;

    mac_slice dut (
        .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .ce_mul(ce_mul), .ce_out(ce_out),
        .srst_in_n(srst_in_n), .srst_mul_n(srst_mul_n), .srst_out_n(srst_out_n),
        .mode(mode), .a(a), .b(b), .d(d), .c(c), .carry_in(carry_in),
        .cascade_in(cascade_in), .result(result), .cascade_out(cascade_out),
        .carry_out(carry_out)
    );

    function automatic longint wrap18(longint x);
        logic [17:0] t;
        t = 18'(x);
        return longint'($signed(t));
    endfunction

    // Advance the reference by one edge, last stage first
    task automatic model_step();
        logic [47:0] opnd;
        logic [48:0] s;
        longint      pre;
        if (!rst_n || !srst_out_n) begin
            r_p = '0; r_co = 1'b0;
        end else if (ce_out) begin
            case (r2_sel)
                2'd0:    opnd = '0;
                2'd1:    opnd = r2_c;
                2'd2:    opnd = r_p;
                default: opnd = cascade_in;
            endcase
            s = {1'b0, 48'(r2_prod)} + {1'b0, opnd} + 49'(r2_cin);
            r_p = s[47:0]; r_co = s[48];
        end
        if (!rst_n || !srst_mul_n) begin
            r2_prod = 0; r2_c = '0; r2_sel = '0; r2_cin = 1'b0;
        end else if (ce_mul) begin
            if (r1_mode[1]) pre = wrap18(r1_mode[0] ? r1_d - r1_b : r1_d + r1_b);
            else            pre = r1_b;
            r2_prod = r1_a * pre;
            r2_c = r1_c; r2_sel = r1_mode[3:2]; r2_cin = r1_cin;
        end
        if (!rst_n || !srst_in_n) begin
            r1_a = 0; r1_b = 0; r1_d = 0; r1_c = '0; r1_mode = '0; r1_cin = 1'b0;
        end else if (ce_in) begin
            r1_a = longint'(a); r1_b = longint'(b); r1_d = longint'(d);
            r1_c = c; r1_mode = mode; r1_cin = carry_in;
        end
    endtask

    task automatic compare();
        total++;
        if (result !== r_p || carry_out !== r_co) begin
            bad++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     tag, result, carry_out, r_p, r_co);
        end
        total++;
        if (cascade_out !== r_p) begin // R12
            bad++;
            $display("FAIL R12 (%s): cascade_out=%h expected %h", tag, cascade_out, r_p);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        model_step();
        compare();
    endtask

    task automatic rand_ops();
        a = 18'($urandom); b = 18'($urandom); d = 18'($urandom);
        c = {16'($urandom), 32'($urandom)};
        cascade_in = {16'($urandom), 32'($urandom)};
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ce_in = 1'b1; ce_mul = 1'b1; ce_out = 1'b1;
        srst_in_n = 1'b1; srst_mul_n = 1'b1; srst_out_n = 1'b1;
        mode = '0; a = '0; b = '0; d = '0; c = '0; carry_in = 1'b0; cascade_in = '0;
        r1_a = 0; r1_b = 0; r1_d = 0; r1_c = '0; r1_mode = '0; r1_cin = 1'b0;
        r2_prod = 0; r2_c = '0; r2_sel = '0; r2_cin = 1'b0; r_p = '0; r_co = 1'b0;

        // R10: reset state
        tag = "R10";
        repeat (3) cycle();
        rst_n = 1'b1;

        // R1: product only, bit 0 irrelevant while the pre-adder is off
        tag = "R1";
        for (int i = 0; i < 40; i++) begin
            rand_ops(); carry_in = 1'b0; mode = {3'b000, 1'($urandom)}; cycle();
        end
        // R2: pre-add
        tag = "R2";
        for (int i = 0; i < 40; i++) begin
            rand_ops(); mode = 4'b0010; cycle();
        end
        // R3: pre-subtract
        tag = "R3";
        for (int i = 0; i < 40; i++) begin
            rand_ops(); mode = 4'b0011; cycle();
        end
        // R4: plus C
        tag = "R4";
        for (int i = 0; i < 40; i++) begin
            rand_ops(); mode = {2'b01, 2'($urandom)}; cycle();
        end
        // R5: accumulate
        tag = "R5";
        for (int i = 0; i < 40; i++) begin
            rand_ops(); mode = {2'b10, 2'($urandom)}; cycle();
        end
        // R6: cascade addend
        tag = "R6";
        for (int i = 0; i < 40; i++) begin
            rand_ops(); mode = {2'b11, 2'($urandom)}; cycle();
        end
        // R7: carry-in and carry-out under any mode
        tag = "R7";
        for (int i = 0; i < 60; i++) begin
            rand_ops(); carry_in = 1'($urandom); mode = 4'($urandom); cycle();
        end
        carry_in = 1'b0;

        // R8: boundary values
        tag = "R8";
        a = -18'sd131072; b = -18'sd131072; mode = 4'b0000;
        repeat (4) cycle();                 // largest positive product
        a = 18'sd1; b = 18'sd1; c = 48'hFFFF_FFFF_FFFF; mode = 4'b0100;
        repeat (4) cycle();                 // wraps to zero with carry
        a = 18'sd1; d = 18'sd131071; b = 18'sd1; mode = 4'b0010;
        repeat (4) cycle();                 // pre-adder wraps to -131072
        a = 18'sd131071; d = -18'sd131072; b = 18'sd1; mode = 4'b0011;
        repeat (4) cycle();                 // pre-subtract wraps to +131071
        a = -18'sd131072; b = 18'sd131071; mode = 4'b1000;
        repeat (30) cycle();                // long accumulation wraps at 2^48

        // R9: random clock enables
        tag = "R9";
        for (int i = 0; i < 120; i++) begin
            rand_ops(); mode = 4'($urandom); carry_in = 1'($urandom);
            ce_in = 1'($urandom); ce_mul = 1'($urandom); ce_out = 1'($urandom);
            cycle();
        end
        ce_in = 1'b1; ce_mul = 1'b1; ce_out = 1'b1;

        // R10: per-stage clears and a global reset pulse
        tag = "R10";
        for (int i = 0; i < 120; i++) begin
            rand_ops(); mode = 4'($urandom); carry_in = 1'($urandom);
            srst_in_n  = ($urandom % 8) != 0;
            srst_mul_n = ($urandom % 8) != 0;
            srst_out_n = ($urandom % 8) != 0;
            rst_n      = (i != 60);
            cycle();
        end
        srst_in_n = 1'b1; srst_mul_n = 1'b1; srst_out_n = 1'b1; rst_n = 1'b1;

        // R11: mode changes every cycle, latency follows each operand set
        tag = "R11";
        for (int i = 0; i < 100; i++) begin
            rand_ops(); mode = 4'($urandom); carry_in = 1'($urandom); cycle();
        end
        mode = 4'b0000; a = '0; b = '0;
        repeat (4) cycle();

        finish_run();
    end

endmodule